// File: doc/BRIEF.md
# Period-Match Timer with Multi-Role Pin

This block is a free-running up-counter that compares its value against a programmed period. When the two are equal on a counting step, the counter restarts from zero and the block raises a one-cycle interrupt strobe. One external pin is tied to the timer. A three-bit role field in the control register decides what that pin does. It can be an output that shows each match as a one-cycle pulse or as a level that flips. It can be an input whose rising edges replace the internal clock as the count source. It can be an input that lets the counter advance only while the pin is high. Or it can be a plain general-purpose I/O under register control.

Software programs the block through a small word-wide register port with four locations:

| Address | Content | Access |
|---------|---------|--------|
| 0 | Period | write and read |
| 1 | Control | write and read |
| 2 | Current count | read only |
| 3 | Pin status | read only |

The pin is modelled as three plain signals: the sampled level coming in, the driven level going out, and an output enable. All external inputs are resynchronised with two flops before any logic uses them.

Top module: `pin_timer`

## Requirements
- R1: The counter advances by one on each counting step while the run bit (control bit 0) is set. On a step where the count equals the period (address 0), the counter reloads to 0. The count is readable at address 2.
- R2: Each match raises `irq` for exactly one clock cycle, in the cycle after the matching step, so that with the internal clock and period P, strobes are P+1 cycles apart.
- R3: With role 1 (pulse output, control bits 3:1), `pin_oe` is 1 and `pin_out` carries a one-cycle high pulse that coincides with each `irq`.
- R4: With role 2 (toggle output), `pin_oe` is 1 and `pin_out` inverts on each match, in the same cycle as `irq`, starting from 0 after reset. The toggle level is readable at address 3 bit 1.
- R5: With role 3 (external clock), `pin_oe` is 0. The counter advances once per rising edge of `pin_in`, detected after a two-flop synchroniser, and does not advance while the pin holds a level.
- R6: With role 4 (gate), `pin_oe` is 0. The counter advances on every clock in which the synchronised pin is high, so a pin held high for N cycles adds exactly N to the count.
- R7: With role 0 (GPIO), `pin_oe` follows control bit 4 (1 = drive), and `pin_out` follows control bit 5 while driving. The synchronised pin level is readable at address 3 bit 0.
- R8: After reset, `pin_oe`, `pin_out` and `irq` are 0, and the count, period and control all read 0, so the pin is an input.
- R9: Role codes 5 to 7 behave as GPIO input: `pin_oe` and `pin_out` stay 0 whatever control bits 4 and 5 hold.
- R10: While the run bit is clear, the count stays at 0 and no `irq` occurs.
- R11: The period and control registers read back the last value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for reg_addr, combinational |
| pin_in | input | 1 | Level sensed on the pin |
| pin_out | output | 1 | Level driven onto the pin |
| pin_oe | output | 1 | Pin output enable, 1 = drive |
| irq | output | 1 | One-cycle match strobe |

## Verification
The bench targets three areas.

The first is the exact synchroniser latency in gate mode. A pin held high for seven cycles must add exactly seven. A design that samples the raw pin, or that counts the synchroniser stages unevenly, ends one count off.

The second is edge counting in external clock mode. A design that counts levels instead of edges runs away while the pin stays high. One that ignores the reload would miss the strobe on the third edge.

The third is the output and encoding corner cases. The strobe spacing must be P+1 and not P. The toggle must start from 0 and flip only with a strobe. Illegal role codes combined with a set direction bit must leave the pin undriven; a design that decodes the direction bit on its own would drive the pin there.

// File: rtl/pin_timer.sv
`timescale 1ns/1ps
module pin_timer #(
  parameter int CNT_W = 16,
  parameter int AW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             irq
);
  localparam int CW = 6;
  localparam logic [2:0] M_GPIO  = 3'd0;
  localparam logic [2:0] M_PULSE = 3'd1;
  localparam logic [2:0] M_TOG   = 3'd2;
  localparam logic [2:0] M_ECLK  = 3'd3;
  localparam logic [2:0] M_GATE  = 3'd4;
  localparam logic [AW-1:0] A_PER = AW'(0);
  localparam logic [AW-1:0] A_CTL = AW'(1);
  localparam logic [AW-1:0] A_CNT = AW'(2);
  localparam logic [AW-1:0] A_PIN = AW'(3);

  logic [CNT_W-1:0] period_q, cnt;
  logic [CW-1:0]    ctl_q;
  logic [2:0]       sh;
  logic             tog, irq_q, tick, hit;
  logic             run, gdir, gval, pin_s, rise;
  logic [2:0]       mode;

  assign run   = ctl_q[0];
  assign mode  = ctl_q[3:1];
  assign gdir  = ctl_q[4];
  assign gval  = ctl_q[5];
  assign pin_s = sh[1];
  assign rise  = sh[1] & ~sh[2];
  assign hit   = run && tick && (cnt == period_q);
  assign irq   = irq_q;

  always_comb begin
    case (mode)
      M_ECLK:  tick = rise;
      M_GATE:  tick = pin_s;
      default: tick = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[1:0], pin_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      ctl_q    <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_PER:   period_q <= reg_wdata;
        A_CTL:   ctl_q    <= reg_wdata[CW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run)          cnt <= '0;
    else if (hit)           cnt <= '0;
    else if (tick)          cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      tog   <= 1'b0;
    end else begin
      irq_q <= hit;
      if (hit && mode == M_TOG) tog <= ~tog;
    end
  end

  always_comb begin
    case (mode)
      M_PULSE: begin pin_oe = 1'b1; pin_out = irq_q;       end
      M_TOG:   begin pin_oe = 1'b1; pin_out = tog;         end
      M_GPIO:  begin pin_oe = gdir; pin_out = gdir & gval; end
      default: begin pin_oe = 1'b0; pin_out = 1'b0;        end
    endcase
  end

  always_comb begin
    case (reg_addr)
      A_PER:   reg_rdata = period_q;
      A_CTL:   reg_rdata = {{(CNT_W-CW){1'b0}}, ctl_q};
      A_CNT:   reg_rdata = cnt;
      A_PIN:   reg_rdata = {{(CNT_W-2){1'b0}}, tog, pin_s};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pin_timer_chk.sv
`timescale 1ns/1ps
module pin_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             pin_oe,
  input logic             pin_out,
  input logic [2:0]       mode,
  input logic             run,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] period_q
);
  // R8
  always @(posedge clk) begin
    if (!rst_n) reset_idle_chk: assert (!pin_oe && !irq);
  end

  // R1
  match_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cnt == '0);

  // R2
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && period_q != '0) |=> !irq);

  // R4
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && mode == 3'd2 && $past(mode) == 3'd2) |-> pin_out != $past(pin_out));

  // R5
  input_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode >= 3'd3) |-> !pin_oe);

  // R10
  stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0 && !irq));
endmodule

bind pin_timer pin_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq(irq), .pin_oe(pin_oe), .pin_out(pin_out),
  .mode(mode), .run(run), .cnt(cnt), .period_q(period_q)
);

// File: tb/pin_timer_tb.sv
`timescale 1ns/1ps
module pin_timer_tb_top;
  localparam int W = 16;
  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, pin_in = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [W-1:0] reg_wdata = '0, reg_rdata;
  logic pin_out, pin_oe, irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pin_timer #(.CNT_W(W), .AW(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = W'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic t_reset();
    int v;
    chk(pin_oe == 1'b0, "R8 oe", pin_oe, 0);
    chk(pin_out == 1'b0, "R8 out", pin_out, 0);
    chk(irq == 1'b0, "R8 irq", irq, 0);
    rd(2'd2, v); chk(v == 0, "R8 count", v, 0);
    rd(2'd0, v); chk(v == 0, "R8 period", v, 0);
    rd(2'd1, v); chk(v == 0, "R8 control", v, 0);
  endtask

  task automatic t_readback();
    int v;
    wr(2'd0, 16'h1234);
    wr(2'd1, 6'h2A);
    rd(2'd0, v); chk(v == 16'h1234, "R11 period", v, 16'h1234);
    rd(2'd1, v); chk(v == 6'h2A, "R11 control", v, 6'h2A);
    wr(2'd1, 0);
  endtask

  task automatic t_stopped();
    int hits = 0, v;
    wr(2'd0, 2);
    wr(2'd1, 2);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (irq) hits++;
    end
    rd(2'd2, v);
    chk(hits == 0, "R10 no irq", hits, 0);
    chk(v == 0, "R10 count held", v, 0);
  endtask

  task automatic t_pulse();
    int first = -1, second = -1, bad = 0, prev = 0;
    wr(2'd1, 0);
    wr(2'd0, 4);
    wr(2'd1, 3);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pin_out != irq || !pin_oe) bad++;
      if (irq && prev == 1) bad++;
      if (irq) begin
        if (first < 0) first = i;
        else if (second < 0) second = i;
      end
      prev = irq;
    end
    chk(second - first == 5, "R2 strobe spacing", second - first, 5);
    chk(first >= 0, "R1 match seen", first, 0);
    chk(bad == 0, "R3 pulse pin", bad, 0);
  endtask

  task automatic t_toggle();
    int flips = 0, hits = 0, bad = 0, v;
    logic prev;
    wr(2'd1, 0);
    chk(pin_out == 1'b0, "R4 initial toggle", pin_out, 0);
    wr(2'd0, 3);
    wr(2'd1, 5);
    prev = pin_out;
    chk(prev == 1'b0 && pin_oe, "R4 start low driven", prev, 0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (irq) hits++;
      if (pin_out != prev) begin
        flips++;
        if (!irq) bad++;
      end
      prev = pin_out;
    end
    rd(2'd3, v);
    chk(flips == hits && hits >= 6, "R4 flip per match", flips, hits);
    chk(bad == 0, "R4 flip with irq", bad, 0);
    chk(((v >> 1) & 1) == int'(pin_out), "R4 toggle readback", (v >> 1) & 1, int'(pin_out));
    wr(2'd1, 0);
  endtask

  task automatic edge_pulse(inout int hits);
    @(negedge clk); pin_in = 1'b1;
    for (int i = 0; i < 3; i++) begin @(negedge clk); if (irq) hits++; end
    pin_in = 1'b0;
    for (int i = 0; i < 3; i++) begin @(negedge clk); if (irq) hits++; end
  endtask

  task automatic t_extclk();
    int hits = 0, v;
    wr(2'd1, 0);
    wr(2'd0, 2);
    wr(2'd1, 7);
    repeat (6) @(negedge clk);
    rd(2'd2, v); chk(v == 0, "R5 no edge no count", v, 0);
    chk(pin_oe == 1'b0, "R5 pin is input", pin_oe, 0);
    edge_pulse(hits); rd(2'd2, v); chk(v == 1, "R5 first edge", v, 1);
    edge_pulse(hits); rd(2'd2, v); chk(v == 2, "R5 second edge", v, 2);
    edge_pulse(hits); rd(2'd2, v); chk(v == 0, "R1 reload on edge", v, 0);
    chk(hits == 1, "R5 one strobe", hits, 1);
    edge_pulse(hits);
    @(negedge clk); pin_in = 1'b1;
    repeat (10) @(negedge clk);
    rd(2'd2, v); chk(v == 2, "R5 level held no count", v, 2);
    pin_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_gate();
    int v;
    wr(2'd1, 0);
    wr(2'd0, 100);
    wr(2'd1, 9);
    repeat (5) @(negedge clk);
    rd(2'd2, v); chk(v == 0, "R6 gate closed", v, 0);
    chk(pin_oe == 1'b0, "R6 pin is input", pin_oe, 0);
    @(negedge clk); pin_in = 1'b1;
    repeat (7) @(negedge clk);
    pin_in = 1'b0;
    repeat (5) @(negedge clk);
    rd(2'd2, v); chk(v == 7, "R6 gated count", v, 7);
  endtask

  task automatic t_gpio();
    int v;
    wr(2'd1, 0);
    wr(2'd1, 6'h30);
    chk(pin_oe && pin_out, "R7 drive high", {pin_oe, pin_out}, 3);
    wr(2'd1, 6'h10);
    chk(pin_oe && !pin_out, "R7 drive low", {pin_oe, pin_out}, 2);
    wr(2'd1, 6'h20);
    chk(!pin_oe, "R7 input", pin_oe, 0);
    pin_in = 1'b1; repeat (3) @(negedge clk);
    rd(2'd3, v); chk((v & 1) == 1, "R7 read pin high", v & 1, 1);
    pin_in = 1'b0; repeat (3) @(negedge clk);
    rd(2'd3, v); chk((v & 1) == 0, "R7 read pin low", v & 1, 0);
  endtask

  task automatic t_illegal();
    for (int m = 5; m < 8; m++) begin
      wr(2'd1, 6'h30 | (m << 1) | 1);
      repeat (3) @(negedge clk);
      chk(!pin_oe && !pin_out, "R9 illegal role undriven", {pin_oe, pin_out}, 0);
    end
    wr(2'd1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_stopped();
    t_pulse();
    t_toggle();
    t_extclk();
    t_gate();
    t_gpio();
    t_illegal();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule